// File: doc/BRIEF.md
# Periodic Random Head Shuffler

This controller sits beside a single wormhole input queue and, at a programmable interval, tells the queue to exchange its head entry with another entry that it picks pseudo-randomly. When the head flit cannot leave because its output has run out of credits, the exchange lets a flit further back reach the front. Over many intervals, every queued flit has a similar chance of reaching the head. The queue storage and the exchange itself are outside the block. The block only issues an entry index and a one-cycle strobe.

There are two selection modes. In random mode the first drawn entry is accepted. In shuffle mode a drawn entry whose output port equals the head's is rejected, and another entry is drawn on the next cycle. At most four draws are made per interval. A 16-bit maximal-length LFSR supplies the draws. The draw is reduced into the range 1 to occupancy−1, so entry 0 (the head) is never named. A zero interval parks the block and loads the seed into the LFSR.

The controller has three states. ST_IDLE (parked) moves to ST_WAIT when the interval becomes nonzero. ST_WAIT counts down the interval and moves to ST_DRAW when it expires. ST_DRAW makes one draw per cycle. It returns to ST_WAIT on an accepted draw, on the fourth rejected draw, or when no draw is allowed (head not stalled or occupancy below 2). ST_WAIT and ST_DRAW both fall back to ST_IDLE whenever the interval is zero.

Top module: `shf_head_shuffler`

## Requirements
- R1: While cfg_period is 0, swap_go stays low and the LFSR is loaded each cycle with cfg_seed, a zero seed being replaced by 0x0001.
- R2: If cfg_period turns from 0 to P before clock edge 0, the first draw is made at edge P+1, and an accepted draw raises swap_go in the cycle after that edge.
- R3: swap_go is high for exactly one cycle. After the last draw of an interval at edge E, the next interval's first draw is made at edge E+P+1.
- R4: The LFSR is 16 bits and never zero. Its next value is {l[14:0], l[15]^l[13]^l[12]^l[10]}. It advances exactly once per draw and at no other time.
- R5: A draw names entry 1 + (l mod (q_count−1)), where l is the current LFSR value. Entry 0 is never named.
- R6: With cfg_shuffle = 0, the first draw of an interval is always accepted, whatever the port fields hold.
- R7: With cfg_shuffle = 1, a draw is rejected when q_ports[i*3 +: 3] of the drawn entry i equals q_ports[2:0] (the head's port). After a rejection, the next draw is made on the next edge.
- R8: After four rejected draws in one interval, no swap is issued and the interval restarts as in R3.
- R9: When head_stalled is low at a draw edge, no draw is made, the LFSR keeps its value, no swap is issued, and the interval restarts.
- R10: When q_count is below 2 at a draw edge, the block behaves as in R9.
- R11: After reset, swap_go and swap_idx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 8 | Shuffle interval in cycles; 0 parks the block |
| cfg_shuffle | input | 1 | 0 = random mode, 1 = shuffle mode (distinct port) |
| cfg_seed | input | 16 | LFSR seed, loaded while parked |
| head_stalled | input | 1 | Head flit blocked by zero credits at its output |
| q_count | input | 4 | Number of valid queue entries (0 to 8) |
| q_ports | input | 24 | 3-bit output port of each entry; entry 0 is the head |
| swap_idx | output | 3 | Entry to exchange with the head |
| swap_go | output | 1 | One-cycle swap command |

## Verification
All timing is counted from the edge at which cfg_period becomes nonzero. The first draw falls P+1 edges later, and each accepted draw shows on swap_go one register stage after its edge. Each rejected draw in shuffle mode pushes the next draw out by one edge, and each new interval starts P+1 edges after the previous interval's last draw. The bench computes the exact cycle number and index of every expected pulse from these rules and its own LFSR. It samples swap_go on the falling edge of that cycle and flags any pulse that arrives earlier. The quiet cases (parked, head not stalled, occupancy below 2, all ports equal in shuffle mode) are checked by watching swap_go for windows several intervals long. After a stall window, the index of the next pulse shows that the LFSR did not move during that window.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DRAW = 2'd2
    } shf_state_t;

    // Maximal-length feedback for x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] cur);
        return {cur[LFSR_W-2:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
    endfunction

endpackage

// File: rtl/shf_lfsr.sv
module shf_lfsr
    import shf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] value
);

    logic [LFSR_W-1:0] seed_fixed;

    // A zero seed would lock the register, so substitute one
    assign seed_fixed = (seed == '0) ? LFSR_W'(1) : seed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= LFSR_W'(1);
        end else if (load) begin
            value <= seed_fixed;
        end else if (step) begin
            value <= lfsr_advance(value);
        end
    end

    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0);

    assert_lfsr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(value));

endmodule

// File: rtl/shf_timer.sv
module shf_timer #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PERIOD_W-1:0] period,
    input  logic                dec,
    output logic                expire
);

    logic [PERIOD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - PERIOD_W'(1);
        end
    end

    assign expire = (cnt_q == PERIOD_W'(1));

    assert_timer_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);

endmodule

// File: rtl/shf_pick.sv
module shf_pick
    import shf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PORT_W = 3,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic [LFSR_W-1:0]       rnd,
    input  logic [CNT_W-1:0]        count,
    input  logic [DEPTH*PORT_W-1:0] ports,
    input  logic                    shuffle,
    output logic                    viable,
    output logic [IDX_W-1:0]        cand_idx,
    output logic                    cand_ok
);

    logic [PORT_W-1:0] port_arr [DEPTH];
    logic [LFSR_W-1:0] span;
    logic [LFSR_W-1:0] rem;
    logic [PORT_W-1:0] cand_port;

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign port_arr[g] = ports[g*PORT_W +: PORT_W];
    end

    assign viable = (count >= CNT_W'(2));
    assign span   = viable ? (LFSR_W'(count) - LFSR_W'(1)) : LFSR_W'(1);
    assign rem    = rnd % span;

    // Offset by one so the head slot is never named
    assign cand_idx  = IDX_W'(rem) + IDX_W'(1);
    assign cand_port = port_arr[cand_idx];
    assign cand_ok   = !shuffle || (cand_port != port_arr[0]);

endmodule

// File: rtl/shf_head_shuffler.sv
module shf_head_shuffler
    import shf_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int PORT_W    = 3,
    parameter int PERIOD_W  = 8,
    parameter int MAX_TRIES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PERIOD_W-1:0]           cfg_period,
    input  logic                          cfg_shuffle,
    input  logic [LFSR_W-1:0]             cfg_seed,
    input  logic                          head_stalled,
    input  logic [$clog2(DEPTH+1)-1:0]    q_count,
    input  logic [DEPTH*PORT_W-1:0]       q_ports,
    output logic [$clog2(DEPTH)-1:0]      swap_idx,
    output logic                          swap_go
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TRY_W = $clog2(MAX_TRIES);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

    shf_state_t        state_q, state_d;
    logic [TRY_W-1:0]  tries_q, tries_d;
    logic              enabled;
    logic              tmr_load, tmr_dec, tmr_expire;
    logic              lfsr_load, lfsr_step;
    logic [LFSR_W-1:0] rnd;
    logic              viable, cand_ok;
    logic [IDX_W-1:0]  cand_idx;
    logic              go_d;

    assign enabled = (cfg_period != '0);

    shf_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lfsr_load),
        .seed  (cfg_seed),
        .step  (lfsr_step),
        .value (rnd)
    );

    shf_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .period (cfg_period),
        .dec    (tmr_dec),
        .expire (tmr_expire)
    );

    shf_pick #(
        .DEPTH  (DEPTH),
        .PORT_W (PORT_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .rnd      (rnd),
        .count    (q_count),
        .ports    (q_ports),
        .shuffle  (cfg_shuffle),
        .viable   (viable),
        .cand_idx (cand_idx),
        .cand_ok  (cand_ok)
    );

    // State and retry register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tries_q <= '0;
        end else begin
            state_q <= state_d;
            tries_q <= tries_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d   = state_q;
        tries_d   = tries_q;
        tmr_load  = 1'b0;
        tmr_dec   = 1'b0;
        lfsr_load = 1'b0;
        lfsr_step = 1'b0;
        go_d      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                lfsr_load = 1'b1;
                tries_d   = '0;
                if (enabled) begin
                    tmr_load = 1'b1;
                    state_d  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!enabled) begin
                    state_d = ST_IDLE;
                end else if (tmr_expire) begin
                    tries_d = '0;
                    state_d = ST_DRAW;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_DRAW: begin
                if (!enabled) begin
                    state_d = ST_IDLE;
                end else if (!head_stalled || !viable) begin
                    tmr_load = 1'b1;
                    state_d  = ST_WAIT;
                end else begin
                    lfsr_step = 1'b1;
                    if (cand_ok) begin
                        go_d     = 1'b1;
                        tmr_load = 1'b1;
                        state_d  = ST_WAIT;
                    end else if (tries_q == LAST_TRY) begin
                        tmr_load = 1'b1;
                        state_d  = ST_WAIT;
                    end else begin
                        tries_d = tries_q + TRY_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Registered swap command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swap_go  <= 1'b0;
            swap_idx <= '0;
        end else begin
            swap_go <= go_d;
            if (go_d) begin
                swap_idx <= cand_idx;
            end
        end
    end

    function automatic logic [PORT_W-1:0] port_at(
        input logic [DEPTH*PORT_W-1:0] vec,
        input logic [IDX_W-1:0]        idx
    );
        return vec[int'(idx)*PORT_W +: PORT_W];
    endfunction

    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |-> $past(cfg_period) != '0);

    assert_go_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |=> !swap_go);

    assert_head_excluded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |-> swap_idx != '0);

    assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |-> CNT_W'(swap_idx) < $past(q_count));

    assert_distinct_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_go && $past(cfg_shuffle)) |->
            port_at($past(q_ports), swap_idx) != $past(q_ports[PORT_W-1:0]));

    assert_stalled_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |-> $past(head_stalled));

    assert_min_occupancy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |-> $past(q_count) >= CNT_W'(2));

endmodule

// File: tb/tb_shf_head_shuffler.sv
`timescale 1ns/1ps
module tb_shf_head_shuffler;

    localparam int DEPTH    = 8;
    localparam int PORT_W   = 3;
    localparam int PERIOD_W = 8;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [PERIOD_W-1:0]        cfg_period = '0;
    logic                       cfg_shuffle = 1'b0;
    logic [15:0]                cfg_seed = 16'h0001;
    logic                       head_stalled = 1'b0;
    logic [3:0]                 q_count = '0;
    logic [DEPTH*PORT_W-1:0]    q_ports = '0;
    logic [2:0]                 swap_idx;
    logic                       swap_go;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_cyc [32];
    int exp_idx [32];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shf_head_shuffler dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_period   (cfg_period),
        .cfg_shuffle  (cfg_shuffle),
        .cfg_seed     (cfg_seed),
        .head_stalled (head_stalled),
        .q_count      (q_count),
        .q_ports      (q_ports),
        .swap_idx     (swap_idx),
        .swap_go      (swap_go)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_nx(input logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    function automatic int port_of(input logic [DEPTH*PORT_W-1:0] v, input int i);
        return int'(v[i*PORT_W +: PORT_W]);
    endfunction

    task automatic park();
        @(negedge clk);
        cfg_period = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet(input string req, input int n);
        int hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (swap_go) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    // Predict pulses from R2..R8, then compare cycle and index of each
    task automatic run_case(input string req, input logic [15:0] seed, input int p,
                            input bit mode, input int cnt,
                            input logic [DEPTH*PORT_W-1:0] ports, input int np);
        logic [15:0] l;
        int t;
        int e;
        int n;
        park();
        cfg_seed = seed; cfg_shuffle = mode; q_count = 4'(cnt);
        q_ports = ports; head_stalled = 1'b1;
        repeat (2) @(negedge clk);
        cfg_period = PERIOD_W'(p);
        e = cyc;
        l = (seed == 16'h0) ? 16'h0001 : seed;
        t = p + 1;
        n = 0;
        while (n < np) begin
            bit done = 0;
            for (int a = 0; a < 4 && !done; a++) begin
                int idx = 1 + int'(l) % (cnt - 1);
                bit ok = !mode || (port_of(ports, idx) != port_of(ports, 0));
                l = lfsr_nx(l);
                if (ok) begin
                    exp_cyc[n] = e + 1 + t;
                    exp_idx[n] = idx;
                    n++;
                    t += p + 1;
                    done = 1;
                end else if (a == 3) begin
                    t += p + 1;
                    done = 1;
                end else begin
                    t += 1;
                end
            end
        end
        for (int k = 0; k < np; k++) begin
            bit early = 0;
            while (cyc < exp_cyc[k]) begin
                @(negedge clk);
                if (cyc < exp_cyc[k] && swap_go) early = 1;
            end
            chk(!early, {req, " no early pulse"}, 1, 0);
            chk(swap_go == 1'b1, {req, " pulse timing"}, int'(swap_go), 1);
            chk(int'(swap_idx) == exp_idx[k], {req, " index"}, int'(swap_idx), exp_idx[k]);
        end
    endtask

    task automatic t_reset();
        chk(swap_go == 1'b0, "R11 go after reset", int'(swap_go), 0);
        chk(swap_idx == 3'd0, "R11 idx after reset", int'(swap_idx), 0);
    endtask

    task automatic t_parked();
        park();
        q_count = 4'd8; head_stalled = 1'b1; q_ports = {8{3'd1}} ^ 24'o01234567;
        quiet("R1 parked", 60);
    endtask

    task automatic t_not_stalled();
        int waited = 0;
        int exp;
        park();
        cfg_seed = 16'h1234; cfg_shuffle = 1'b0; q_count = 4'd8;
        q_ports = 24'o76543210; head_stalled = 1'b0;
        repeat (2) @(negedge clk);
        cfg_period = 8'd3;
        quiet("R9 head not stalled", 30);
        head_stalled = 1'b1;
        exp = 1 + int'(16'h1234) % 7;
        while (!swap_go && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(swap_go == 1'b1, "R9 swap after stall", int'(swap_go), 1);
        chk(int'(swap_idx) == exp, "R9 LFSR unchanged", int'(swap_idx), exp);
    endtask

    task automatic t_low_count();
        park();
        cfg_seed = 16'h00FF; cfg_shuffle = 1'b0; q_count = 4'd1;
        q_ports = 24'o76543210; head_stalled = 1'b1;
        repeat (2) @(negedge clk);
        cfg_period = 8'd2;
        quiet("R10 occupancy one", 40);
        q_count = 4'd0;
        quiet("R10 occupancy zero", 40);
    endtask

    task automatic t_all_same();
        park();
        cfg_seed = 16'hBEEF; cfg_shuffle = 1'b1; q_count = 4'd8;
        q_ports = {8{3'd5}}; head_stalled = 1'b1;
        repeat (2) @(negedge clk);
        cfg_period = 8'd3;
        quiet("R8 shuffle all ports equal", 120);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parked();
        run_case("R6 random equal ports", 16'hACE1, 5, 1'b0, 8, {8{3'd2}}, 6);
        run_case("R5 occupancy two", 16'h5A5A, 3, 1'b0, 2, 24'o00000031, 4);
        run_case("R2 period one", 16'h0F0F, 1, 1'b0, 6, 24'o00543210, 5);
        run_case("R1 zero seed", 16'h0000, 4, 1'b0, 8, 24'o76543210, 4);
        run_case("R7 shuffle mixed", 16'h1357, 4, 1'b1, 8, 24'o12121212, 8);
        run_case("R8 shuffle sparse", 16'h2468, 2, 1'b1, 3, 24'o00000400, 12);
        t_all_same();
        t_not_stalled();
        t_low_count();
        run_case("R3 random reload", 16'hC0DE, 7, 1'b0, 5, 24'o00043210, 4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule